// File: doc/BRIEF.md
# External Cache Fast Access Controller

This block sequences single CPU accesses to an external write-back cache made of a tag RAM and a data RAM. A cache line holds two data beats. For a read, the block looks up the tag and reads beat 0 in the same access window. It reads beat 1 only if the lookup hits, and then returns both beats together. For a write, it first does a tag lookup. On a hit it stores one beat, using its byte enables, and sets the line's dirty bit. A miss on either kind of access raises a block request toward a system-bus engine, waits for that request to be taken, and then reports the miss to the CPU. It does not touch the data RAM on a miss.

The length of each RAM access comes from two configuration fields. A read window lasts the read-speed value plus 1 cycles. A write window lasts the write-speed value plus 1 cycles. Both fields are sampled when a request is accepted. Requests arrive on a valid/ready channel, and only one access is in flight at a time.

Responses and system-bus requests are also valid/ready channels. Each holds its payload stable until the consumer takes it. The CPU sees a completed access as a one-cycle `rsp_valid && rsp_ready` handshake. RAM read data is sampled by the block on the last cycle of each read window.

Top module: `ecache_fast_ctrl`

## Requirements
- R1: After a read is accepted, the first window lasts cfg_rd_spd+1 cycles. During it `dat_oe_n` is 0, `dat_addr` is {index,0} and `tag_idx` is the request index. Address layout: bit 0 is the beat, the next IDXW bits are the index, and the upper TAGW bits are the tag.
- R2: On a read hit, a second window of cfg_rd_spd+1 cycles follows, with `dat_oe_n`=0 and `dat_addr`={index,1}. The response then has `rsp_hit`=1 and `rsp_data`={beat1,beat0}.
- R3: On a read miss, no second data access is made. `sysreq_valid` rises with `sysreq_write`=0 and `sysreq_addr`={tag,index}. The response that follows has `rsp_hit`=0 and `rsp_data`=0.
- R4: A hit means the stored tag equals the request tag and the stored valid bit is 1. A matching tag with valid 0 is a miss.
- R5: A write first runs a lookup window of cfg_rd_spd+1 cycles with `dat_oe_n`=1 and `dat_we`=0. On a hit, a window of cfg_wr_spd+1 cycles follows with `dat_we`=1, `dat_addr`={index,beat}, `dat_be`=request enables, and `dirty_set`=1 in its last cycle only. The response then has `rsp_hit`=1.
- R6: In a masked write, byte lanes whose enable is 0 keep their old RAM contents.
- R7: On a write miss, `sysreq_valid` rises with `sysreq_write`=1. Neither `dat_we` nor `dirty_set` is asserted, and the response has `rsp_hit`=0.
- R8: `dat_oe_n` is 0 only during read data windows. It is never 0 while `dat_we` is 1.
- R9: `req_ready` is 1 only when idle. It drops in the cycle after acceptance and stays 0 until the response handshake completes.
- R10: While `rsp_ready`=0, `rsp_valid` and `rsp_data` hold. While `sysreq_ready`=0, `sysreq_valid` and `sysreq_addr` hold.
- R11: Changes to `cfg_rd_spd` or `cfg_wr_spd` after acceptance do not change the window lengths of that access.
- R12: After reset, `req_ready`=1, `rsp_valid`=0, `sysreq_valid`=0, `dat_oe_n`=1, `dat_we`=0 and `dirty_set`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_rd_spd | input | SPDW | Read window length minus one |
| cfg_wr_spd | input | SPDW | Write window length minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | TAGW+IDXW+1 | {tag, index, beat} |
| req_wdata | input | DW | Write beat |
| req_be | input | DW/8 | Byte enables for the write |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | 1 = served from the cache |
| rsp_data | output | 2*DW | {beat1, beat0} on a read hit, otherwise 0 |
| sysreq_valid | output | 1 | Block request to system bus |
| sysreq_ready | input | 1 | Block request taken |
| sysreq_write | output | 1 | 1 = write block, 0 = read block |
| sysreq_addr | output | TAGW+IDXW | Line address {tag, index} |
| tag_idx | output | IDXW | Tag RAM index |
| tag_rd_tag | input | TAGW | Stored tag |
| tag_rd_valid | input | 1 | Stored valid bit |
| dirty_set | output | 1 | Set the dirty bit of line tag_idx |
| dat_addr | output | IDXW+1 | Data RAM address {index, beat} |
| dat_oe_n | output | 1 | Data RAM output enable, active low |
| dat_we | output | 1 | Data RAM write enable |
| dat_be | output | DW/8 | Data RAM byte enables |
| dat_wdata | output | DW | Data RAM write data |
| dat_rdata | input | DW | Data RAM read data |

## Verification
The bench tries a read hit at the nominal speed and at the shortest speed. The shortest speed separates off-by-one errors in the window counter from correct timing. A read miss caused by a tag mismatch is set against one caused by a cleared valid bit with a matching tag, which shows that both fields of the hit test matter. Full and partial byte-enable writes, followed by read-back, separate lane masking from whole-word stores. Slow responders on both outgoing channels, and speed fields changed in the middle of an access, show that held payloads and sampled window lengths stay fixed.

// File: rtl/ecache_pkg.sv
package ecache_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD0  = 3'd1,
    S_RD1  = 3'd2,
    S_WPRB = 3'd3,
    S_WR   = 3'd4,
    S_SYS  = 3'd5,
    S_RSP  = 3'd6
  } ec_state_t;
endpackage

// File: rtl/ecache_access_timer.sv
module ecache_access_timer #(
  parameter int SPDW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [SPDW-1:0] limit,
  output logic            last
);
  logic [SPDW-1:0] cnt;

  assign last = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= '0;
    else if (run && !last) cnt <= cnt + 1'b1;
  end

  // R1 / R5: a window never counts beyond its sampled length
  a_r1_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= limit);
endmodule

// File: rtl/ecache_tag_check.sv
module ecache_tag_check #(
  parameter int TAGW = 8
) (
  input  logic [TAGW-1:0] stored_tag,
  input  logic            stored_valid,
  input  logic [TAGW-1:0] want_tag,
  output logic            hit
);
  // R4: both the tag match and the valid bit are required
  assign hit = stored_valid && (stored_tag == want_tag);
endmodule

// File: rtl/ecache_seq.sv
module ecache_seq
  import ecache_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      is_write,
  input  logic      last,
  input  logic      hit,
  input  logic      sys_ack,
  input  logic      rsp_ack,
  output ec_state_t state,
  output logic      start
);
  ec_state_t nxt;

  always_comb begin
    nxt   = state;
    start = 1'b0;
    unique case (state)
      S_IDLE: if (accept) begin
        nxt   = is_write ? S_WPRB : S_RD0;
        start = 1'b1;
      end
      S_RD0: if (last) begin
        if (hit) begin
          nxt   = S_RD1;
          start = 1'b1;
        end else begin
          nxt = S_SYS;
        end
      end
      S_RD1: if (last) nxt = S_RSP;
      S_WPRB: if (last) begin
        if (hit) begin
          nxt   = S_WR;
          start = 1'b1;
        end else begin
          nxt = S_SYS;
        end
      end
      S_WR:  if (last) nxt = S_RSP;
      S_SYS: if (sys_ack) nxt = S_RSP;
      S_RSP: if (rsp_ack) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  // R9: an accepted request always leaves idle
  a_r9_leave_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && accept) |=> state != S_IDLE);
endmodule

// File: rtl/ecache_fast_ctrl.sv
module ecache_fast_ctrl
  import ecache_pkg::*;
#(
  parameter int DW   = 32,
  parameter int TAGW = 8,
  parameter int IDXW = 4,
  parameter int SPDW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SPDW-1:0]        cfg_rd_spd,
  input  logic [SPDW-1:0]        cfg_wr_spd,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [TAGW+IDXW:0]     req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [DW/8-1:0]        req_be,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_hit,
  output logic [2*DW-1:0]        rsp_data,
  output logic                   sysreq_valid,
  input  logic                   sysreq_ready,
  output logic                   sysreq_write,
  output logic [TAGW+IDXW-1:0]   sysreq_addr,
  output logic [IDXW-1:0]        tag_idx,
  input  logic [TAGW-1:0]        tag_rd_tag,
  input  logic                   tag_rd_valid,
  output logic                   dirty_set,
  output logic [IDXW:0]          dat_addr,
  output logic                   dat_oe_n,
  output logic                   dat_we,
  output logic [DW/8-1:0]        dat_be,
  output logic [DW-1:0]          dat_wdata,
  input  logic [DW-1:0]          dat_rdata
);
  localparam int BEW   = DW / 8;
  localparam int AW    = TAGW + IDXW + 1;
  localparam int TAG_LO = IDXW + 1;

  ec_state_t       state;
  logic            start, last, hit, accept, run;
  logic [SPDW-1:0] limit;

  logic            r_write, r_beat, r_hit;
  logic [TAGW-1:0] r_tag;
  logic [IDXW-1:0] r_idx;
  logic [DW-1:0]   r_wdata, r_b0, r_b1;
  logic [BEW-1:0]  r_be;
  logic [SPDW-1:0] r_rd_lat, r_wr_lat;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign run       = (state == S_RD0) || (state == S_RD1) ||
                     (state == S_WPRB) || (state == S_WR);
  assign limit     = (state == S_WR) ? r_wr_lat : r_rd_lat;

  ecache_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .is_write(req_write),
    .last    (last),
    .hit     (hit),
    .sys_ack (sysreq_valid && sysreq_ready),
    .rsp_ack (rsp_valid && rsp_ready),
    .state   (state),
    .start   (start)
  );

  ecache_access_timer #(.SPDW(SPDW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .run  (run),
    .limit(limit),
    .last (last)
  );

  ecache_tag_check #(.TAGW(TAGW)) u_tag (
    .stored_tag  (tag_rd_tag),
    .stored_valid(tag_rd_valid),
    .want_tag    (r_tag),
    .hit         (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_write  <= 1'b0;
      r_beat   <= 1'b0;
      r_hit    <= 1'b0;
      r_tag    <= '0;
      r_idx    <= '0;
      r_wdata  <= '0;
      r_be     <= '0;
      r_b0     <= '0;
      r_b1     <= '0;
      r_rd_lat <= '0;
      r_wr_lat <= '0;
    end else begin
      if (accept) begin
        r_write  <= req_write;
        r_beat   <= req_addr[0];
        r_idx    <= req_addr[IDXW:1];
        r_tag    <= req_addr[AW-1:TAG_LO];
        r_wdata  <= req_wdata;
        r_be     <= req_be;
        r_rd_lat <= cfg_rd_spd;
        r_wr_lat <= cfg_wr_spd;
        r_hit    <= 1'b0;
        r_b0     <= '0;
        r_b1     <= '0;
      end
      if ((state == S_RD0 || state == S_WPRB) && last) begin
        r_hit <= hit;
        if (state == S_RD0 && hit) r_b0 <= dat_rdata;
      end
      if (state == S_RD1 && last) r_b1 <= dat_rdata;
    end
  end

  assign tag_idx      = r_idx;
  assign dat_addr     = {r_idx, (state == S_RD1) ? 1'b1 :
                                (state == S_WR)  ? r_beat : 1'b0};
  assign dat_oe_n     = !((state == S_RD0) || (state == S_RD1));
  assign dat_we       = (state == S_WR);
  assign dat_be       = r_be;
  assign dat_wdata    = r_wdata;
  assign dirty_set    = (state == S_WR) && last;
  assign sysreq_valid = (state == S_SYS);
  assign sysreq_write = r_write;
  assign sysreq_addr  = {r_tag, r_idx};
  assign rsp_valid    = (state == S_RSP);
  assign rsp_hit      = r_hit;
  assign rsp_data     = {r_b1, r_b0};

  // R8: reading and writing the data RAM never overlap
  a_r8_oe_not_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_oe_n |-> !dat_we);
  // R5: dirty is only set together with a data store
  a_r5_dirty_with_store: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_set |-> dat_we);
  // R3 / R7: a block request leaves the data RAM idle
  a_r7_miss_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    sysreq_valid |-> (dat_oe_n && !dat_we && !dirty_set));
  // R9: one access at a time
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10: response back-pressure holds the payload
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)));
  // R10: block request back-pressure holds the payload
  a_r10_sys_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sysreq_valid && !sysreq_ready) |=> (sysreq_valid && $stable(sysreq_addr)));
  // R2: a hit response never coincides with a pending block request
  a_r2_rsp_excl_sys: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_valid, sysreq_valid, !dat_oe_n}) <= 1);
endmodule

// File: tb/ecache_fast_ctrl_test.sv
module ecache_fast_ctrl_test;
  localparam int DW = 32, TAGW = 8, IDXW = 4, SPDW = 3;
  localparam int LINES = 1 << IDXW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SPDW-1:0] cfg_rd_spd = '0, cfg_wr_spd = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [TAGW+IDXW:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW/8-1:0] req_be = '0;
  logic rsp_valid, rsp_hit, rsp_ready = 1'b0;
  logic [2*DW-1:0] rsp_data;
  logic sysreq_valid, sysreq_write, sysreq_ready = 1'b0;
  logic [TAGW+IDXW-1:0] sysreq_addr;
  logic [IDXW-1:0] tag_idx;
  logic [TAGW-1:0] tag_rd_tag;
  logic tag_rd_valid, dirty_set, dat_oe_n, dat_we;
  logic [IDXW:0] dat_addr;
  logic [DW/8-1:0] dat_be;
  logic [DW-1:0] dat_wdata, dat_rdata;

  logic [DW-1:0]   ram_data [2*LINES];
  logic [TAGW-1:0] ram_tag  [LINES];
  logic            ram_vld  [LINES];
  logic            ram_dirty[LINES];
  logic [DW-1:0]   m_data   [2*LINES];
  logic            m_dirty  [LINES];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecache_fast_ctrl #(.DW(DW), .TAGW(TAGW), .IDXW(IDXW), .SPDW(SPDW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_rd_spd(cfg_rd_spd), .cfg_wr_spd(cfg_wr_spd),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data), .sysreq_valid(sysreq_valid), .sysreq_ready(sysreq_ready),
    .sysreq_write(sysreq_write), .sysreq_addr(sysreq_addr), .tag_idx(tag_idx),
    .tag_rd_tag(tag_rd_tag), .tag_rd_valid(tag_rd_valid), .dirty_set(dirty_set),
    .dat_addr(dat_addr), .dat_oe_n(dat_oe_n), .dat_we(dat_we), .dat_be(dat_be),
    .dat_wdata(dat_wdata), .dat_rdata(dat_rdata)
  );

  assign dat_rdata    = ram_data[dat_addr];
  assign tag_rd_tag   = ram_tag[tag_idx];
  assign tag_rd_valid = ram_vld[tag_idx];

  always @(posedge clk) begin
    if (dat_we)
      for (int b = 0; b < DW/8; b++)
        if (dat_be[b]) ram_data[dat_addr][8*b +: 8] <= dat_wdata[8*b +: 8];
    if (dirty_set) ram_dirty[tag_idx] <= 1'b1;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the control outputs against the model's phase
  task automatic cyc(input bit e_oe_n, input bit e_we, input bit e_dirty, input bit e_sys,
                     input bit e_rsp, input logic [IDXW:0] e_addr, input logic [IDXW-1:0] e_idx,
                     input string rq);
    logic [5:0] act, exp;
    act = {dat_oe_n, dat_we, dirty_set, sysreq_valid, rsp_valid, req_ready};
    exp = {e_oe_n, e_we, e_dirty, e_sys, e_rsp, 1'b0};
    chk(act == exp, rq, 64'(act), 64'(exp));
    if (!e_oe_n || e_we) chk(dat_addr == e_addr, {rq, " addr"}, 64'(dat_addr), 64'(e_addr));
    if (!e_oe_n) chk(tag_idx == e_idx, "R1 tag index", 64'(tag_idx), 64'(e_idx));
  endtask

  task automatic run_txn(input bit wr, input logic [TAGW-1:0] tg, input logic [IDXW-1:0] ix,
                         input bit bt, input logic [DW-1:0] wd, input logic [DW/8-1:0] be,
                         input int rs, input int ws, input int sdly, input int rdly,
                         input bit perturb);
    bit hit;
    logic [2*DW-1:0] exp_data;
    cfg_rd_spd = SPDW'(rs);
    cfg_wr_spd = SPDW'(ws);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {tg, ix, bt}; req_wdata = wd; req_be = be;
    chk(req_ready == 1'b1, "R9 idle ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (perturb) begin
      cfg_rd_spd = SPDW'(rs + 3);  // R11: must not alter this access
      cfg_wr_spd = SPDW'(ws + 3);
    end
    hit = ram_vld[ix] && (ram_tag[ix] == tg);  // R4 model of the hit test
    exp_data = (hit && !wr) ? {m_data[2*ix+1], m_data[2*ix]} : '0;
    for (int k = 0; k <= rs; k++) begin
      cyc(wr, 1'b0, 1'b0, 1'b0, 1'b0, {ix, 1'b0}, ix, wr ? "R5 lookup" : "R1 first window");
      @(negedge clk);
    end
    if (hit && !wr) begin
      for (int k = 0; k <= rs; k++) begin
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, {ix, 1'b1}, ix, "R2 second window");
        @(negedge clk);
      end
    end else if (hit && wr) begin
      for (int k = 0; k <= ws; k++) begin
        cyc(1'b1, 1'b1, k == ws, 1'b0, 1'b0, {ix, bt}, ix, "R5 write window");
        chk(dat_be == be, "R5 byte enables", 64'(dat_be), 64'(be));
        @(negedge clk);
      end
      for (int b = 0; b < DW/8; b++)
        if (be[b]) m_data[2*ix+bt][8*b +: 8] = wd[8*b +: 8];
      m_dirty[ix] = 1'b1;
    end else begin
      for (int k = 0; k <= sdly; k++) begin
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, ix, wr ? "R7 miss request" : "R3 miss request");
        chk(sysreq_write == wr, "R3 R7 request kind", 64'(sysreq_write), 64'(wr));
        chk(sysreq_addr == {tg, ix}, "R10 request address", 64'(sysreq_addr), 64'({tg, ix}));
        if (k == sdly) sysreq_ready = 1'b1;
        @(negedge clk);
        sysreq_ready = 1'b0;
      end
    end
    for (int k = 0; k <= rdly; k++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0, ix, "R10 response");
      chk(rsp_hit == hit, "R2 R3 R4 response hit", 64'(rsp_hit), 64'(hit));
      chk(rsp_data == exp_data, "R2 R3 response data", rsp_data, exp_data);
      if (k == rdly) rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
    for (int b = 0; b < 2; b++)
      chk(ram_data[2*ix+b] == m_data[2*ix+b], "R6 RAM contents",
          64'(ram_data[2*ix+b]), 64'(m_data[2*ix+b]));
    chk(ram_dirty[ix] == m_dirty[ix], "R5 R7 dirty bit", 64'(ram_dirty[ix]), 64'(m_dirty[ix]));
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      ram_tag[i]   = TAGW'(i * 3 + 1);
      ram_vld[i]   = (i != 5);
      ram_dirty[i] = 1'b0;
      m_dirty[i]   = 1'b0;
      for (int b = 0; b < 2; b++) begin
        ram_data[2*i+b] = 32'hA500_0000 + 32'(i * 256 + b * 17);
        m_data[2*i+b]   = ram_data[2*i+b];
      end
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({req_ready, rsp_valid, sysreq_valid, dat_oe_n, dat_we, dirty_set} == 6'b100100,
        "R12 reset outputs", 64'({req_ready, rsp_valid, sysreq_valid, dat_oe_n, dat_we, dirty_set}),
        64'(6'b100100));
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 read hit, nominal speed
    run_txn(1'b0, 8'd7, 4'd2, 1'b0, '0, '0, 3, 3, 0, 0, 1'b0);
    // R2 R10 shortest read, slow consumer
    run_txn(1'b0, 8'd4, 4'd1, 1'b1, '0, '0, 0, 0, 0, 2, 1'b0);
    // R3 read miss by tag mismatch, longest speed, slow system bus
    run_txn(1'b0, 8'hEE, 4'd3, 1'b0, '0, '0, 7, 2, 3, 0, 1'b0);
    // R4 matching tag but valid cleared
    run_txn(1'b0, 8'd16, 4'd5, 1'b0, '0, '0, 1, 1, 0, 1, 1'b0);
    // R5 full write hit
    run_txn(1'b1, 8'd7, 4'd2, 1'b1, 32'h1234_5678, 4'hF, 2, 3, 0, 0, 1'b0);
    // R6 masked write, then read back
    run_txn(1'b1, 8'd13, 4'd4, 1'b0, 32'hDEAD_BEEF, 4'b0101, 1, 1, 0, 0, 1'b0);
    run_txn(1'b0, 8'd13, 4'd4, 1'b0, '0, '0, 2, 0, 0, 0, 1'b0);
    // R7 write miss
    run_txn(1'b1, 8'h55, 4'd7, 1'b0, 32'hFFFF_FFFF, 4'hF, 1, 2, 1, 1, 1'b0);
    // R11 speed fields changed mid-access
    run_txn(1'b0, 8'd28, 4'd9, 1'b0, '0, '0, 2, 1, 0, 0, 1'b1);
    run_txn(1'b1, 8'd28, 4'd9, 1'b0, 32'h0BAD_F00D, 4'b1000, 1, 2, 0, 0, 1'b1);
    run_txn(1'b0, 8'd7, 4'd2, 1'b0, '0, '0, 0, 0, 0, 0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule